// File: doc/BRIEF.md
# Oscillator-Driven Complex Down-Conversion Mixer

This block moves a carrier that sits at a fixed offset in a complex sample stream down to zero frequency. A phase accumulator steps by a fixed, negative phase increment on every accepted input sample. A small pseudo-random dither is added to the phase, which is then cut down to a 12-bit angle. That angle addresses a quarter-wave sine table to produce a cosine and sine pair, which together form the local-oscillator sample. Each complex input sample is multiplied by this oscillator sample as a full complex product.

The product is brought back to the input's fixed-point format with convergent rounding and saturation. It leaves the block four clock edges after the input, with a valid flag that follows the input's valid flag. The increment is set by a parameter; the default, -2^30, corresponds to a quarter of the sample rate. Because the sign of the increment already points the oscillator at negative frequency, no conjugate is needed. The block sits directly ahead of a decimating filter chain.

Top module: `nco_mixer`

## Requirements
- R1: While reset is asserted, and on the first cycles after it is released, out_valid is 0. The phase accumulator restarts at 0, so the first accepted sample is mixed at angle 0 (cosine 16384, sine 0).
- R2: out_valid equals in_valid as sampled four rising clock edges earlier. out_re and out_im carry the result of that sample.
- R3: The 32-bit phase accumulator adds PHASE_INC modulo 2^32 after each cycle with in_valid high. A sample uses the accumulator value present in its own cycle. The default increment is -2^30.
- R4: A 16-bit LFSR starts at 0xACE1 and steps on every clock edge out of reset. Its next bit 0 is the XOR of bits 15, 13, 12 and 10, and the value shifts left. The low 4 LFSR bits are added to the accumulator at bit position 16. Bits 31..20 of that sum form the 12-bit angle p.
- R5: The oscillator gives cos = round(cos(2*pi*p/4096) * 16384) and sin = round(sin(2*pi*p/4096) * 16384), with ties rounded away from zero. Both are signed 16-bit values with 14 fractional bits.
- R6: Before requantization, the complex product is re = in_re*cos - in_im*sin and im = in_re*sin + in_im*cos, with no conjugation.
- R7: Both product parts are divided by 2^14 with round-half-to-even. A remainder of exactly half rounds toward the even result.
- R8: A rounded result above 32767 is output as 32767, and one below -32768 is output as -32768.
- R9: Cycles with in_valid low do not advance the phase, and their input data has no effect on any later output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample qualifier |
| in_re | input | 16 | Input real part, signed, 14 fractional bits |
| in_im | input | 16 | Input imaginary part, signed, 14 fractional bits |
| out_valid | output | 1 | Output sample qualifier |
| out_re | output | 16 | Mixed real part, signed, 14 fractional bits |
| out_im | output | 16 | Mixed imaginary part, signed, 14 fractional bits |

## Verification
A wrong accumulator or dither state changes the oscillator angle. It shows up as a wrong out_re or out_im on the very next valid output, four edges after the affected sample. The angle error keeps building over the samples that follow. A wrong quadrant or table entry shows as a sign or magnitude error at the output four edges later. A slip in the valid pipeline shows as out_valid disagreeing with the delayed in_valid within a gap of the input stream. The default increment lands exactly on quadrant boundaries, so a second, finely tuned increment is what exposes the dither carry into the angle and the table interior.

// File: rtl/nco_mixer.sv
`timescale 1ns/1ps
module nco_mixer #(
  parameter int     DATA_W    = 16,
  parameter int     FRAC_W    = 14,
  parameter int     ACC_W     = 32,
  parameter int     QPH_W     = 12,
  parameter int     DITHER_W  = 4,
  parameter longint PHASE_INC = -(64'sd1 <<< 30)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic signed [DATA_W-1:0] in_re,
  input  logic signed [DATA_W-1:0] in_im,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_re,
  output logic signed [DATA_W-1:0] out_im
);

  localparam int LUT_W  = QPH_W - 2;
  localparam int LUT_N  = 1 << LUT_W;
  localparam int DSH    = ACC_W - QPH_W - DITHER_W;
  localparam int SUM_W  = 2 * DATA_W + 1;
  localparam int LFSR_W = 16;
  localparam logic [ACC_W-1:0] INC = ACC_W'(PHASE_INC);
  localparam logic signed [SUM_W-1:0] SMAX = SUM_W'((64'sd1 <<< (DATA_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SMIN = -SMAX - 1;
  localparam logic [FRAC_W-1:0] HALF = FRAC_W'(1) << (FRAC_W - 1);

  function automatic logic [DATA_W-1:0] qsin(input int k);
    real ang;
    ang = 2.0 * 3.141592653589793 * k / (4.0 * LUT_N);
    return DATA_W'($rtoi($sin(ang) * (2.0 ** FRAC_W) + 0.5));
  endfunction

  function automatic logic signed [DATA_W-1:0] rnd_sat(input logic signed [SUM_W-1:0] v);
    logic signed [SUM_W-1:0] fl;
    logic [FRAC_W-1:0]       rem;
    logic                    up;
    fl  = v >>> FRAC_W;
    rem = v[FRAC_W-1:0];
    up  = (rem > HALF) || ((rem == HALF) && fl[0]);
    fl  = fl + SUM_W'(up);
    if (fl > SMAX)      return DATA_W'(SMAX);
    else if (fl < SMIN) return DATA_W'(SMIN);
    else                return DATA_W'(fl);
  endfunction

  logic [DATA_W-1:0] lut [LUT_N+1];
  for (genvar g = 0; g <= LUT_N; g++) begin : g_lut
    assign lut[g] = qsin(g);
  end

  logic [LFSR_W-1:0] lfsr;
  logic [ACC_W-1:0]  acc;
  logic [ACC_W-1:0]  dsum;
  logic [QPH_W-1:0]  qph_next;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lfsr <= 16'hACE1;
    else        lfsr <= {lfsr[LFSR_W-2:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)        acc <= '0;
    else if (in_valid) acc <= acc + INC;

  assign dsum     = acc + (ACC_W'(lfsr[DITHER_W-1:0]) << DSH);
  assign qph_next = QPH_W'(dsum >> (ACC_W - QPH_W));

  logic                     s1_v;
  logic [QPH_W-1:0]         s1_ph;
  logic signed [DATA_W-1:0] s1_re, s1_im;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s1_v <= 1'b0; s1_ph <= '0; s1_re <= '0; s1_im <= '0;
    end else begin
      s1_v <= in_valid; s1_ph <= qph_next; s1_re <= in_re; s1_im <= in_im;
    end

  logic [LUT_W-1:0]         lidx;
  logic signed [DATA_W-1:0] lo_a, lo_b, cos_n, sin_n;

  assign lidx = s1_ph[LUT_W-1:0];
  assign lo_a = lut[{1'b0, lidx}];
  assign lo_b = lut[(LUT_W+1)'(LUT_N) - {1'b0, lidx}];

  always_comb begin
    unique case (s1_ph[QPH_W-1 -: 2])
      2'd0:    begin cos_n =  lo_b; sin_n =  lo_a; end
      2'd1:    begin cos_n = -lo_a; sin_n =  lo_b; end
      2'd2:    begin cos_n = -lo_b; sin_n = -lo_a; end
      default: begin cos_n =  lo_a; sin_n = -lo_b; end
    endcase
  end

  logic                     s2_v;
  logic signed [DATA_W-1:0] s2_cos, s2_sin, s2_re, s2_im;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s2_v <= 1'b0; s2_cos <= '0; s2_sin <= '0; s2_re <= '0; s2_im <= '0;
    end else begin
      s2_v <= s1_v; s2_cos <= cos_n; s2_sin <= sin_n; s2_re <= s1_re; s2_im <= s1_im;
    end

  logic                    s3_v;
  logic signed [SUM_W-1:0] s3_re, s3_im;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      s3_v <= 1'b0; s3_re <= '0; s3_im <= '0;
    end else begin
      s3_v  <= s2_v;
      s3_re <= SUM_W'(s2_re) * SUM_W'(s2_cos) - SUM_W'(s2_im) * SUM_W'(s2_sin);
      s3_im <= SUM_W'(s2_re) * SUM_W'(s2_sin) + SUM_W'(s2_im) * SUM_W'(s2_cos);
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      out_valid <= 1'b0; out_re <= '0; out_im <= '0;
    end else begin
      out_valid <= s3_v;
      out_re    <= rnd_sat(s3_re);
      out_im    <= rnd_sat(s3_im);
    end

  logic signed [SUM_W:0] mag2;
  assign mag2 = (SUM_W+1)'(s2_cos) * (SUM_W+1)'(s2_cos) + (SUM_W+1)'(s2_sin) * (SUM_W+1)'(s2_sin);

  // R2
  valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 4));

  // R9
  phase_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(acc));

  // R4
  dither_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    QPH_W'(qph_next - QPH_W'(acc >> (ACC_W - QPH_W))) <= QPH_W'(1));

  // R5
  osc_magnitude_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s2_v |-> (mag2 > (SUM_W+1)'((64'sd1 <<< (2*FRAC_W)) - (64'sd4 <<< FRAC_W))) &&
             (mag2 < (SUM_W+1)'((64'sd1 <<< (2*FRAC_W)) + (64'sd4 <<< FRAC_W))));

  // R5
  sine_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s1_v |=> (s2_sin == '0) || (s2_sin[DATA_W-1] == $past(s1_ph[QPH_W-1])));

endmodule

// File: tb/test_nco_mixer.sv
`timescale 1ns/1ps
module test_nco_mixer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic signed [15:0] in_re = '0, in_im = '0;
  logic ov [2];
  logic signed [15:0] ore [2], oim [2];

  always #5 clk = ~clk;

  nco_mixer i_nco_mixer (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(ov[0]), .out_re(ore[0]), .out_im(oim[0]));

  nco_mixer #(.PHASE_INC(-64'sd313532612)) i_nco_mixer_fine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(ov[1]), .out_re(ore[1]), .out_im(oim[1]));

  int checks = 0, fails = 0, cyc = 0;
  string cur_req = "R1";

  logic [31:0] m_inc [2];
  logic [31:0] m_acc [2];
  logic [15:0] m_lfsr;
  bit  ev [2][4];
  int  er [2][4], ei [2][4];

  function automatic longint osc(input real a);
    if (a >= 0.0) return longint'($rtoi(a * 16384.0 + 0.5));
    else          return -longint'($rtoi(-a * 16384.0 + 0.5));
  endfunction

  function automatic int rq(input longint v);
    longint fl, rem;
    fl  = v >>> 14;
    rem = v - (fl <<< 14);
    if (rem > 8192 || (rem == 8192 && fl[0])) fl = fl + 1;
    if (fl > 32767)  fl = 32767;
    if (fl < -32768) fl = -32768;
    return int'(fl);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_lfsr = 16'hACE1;
      for (int k = 0; k < 2; k++) begin
        m_acc[k] = 32'd0;
        for (int j = 0; j < 4; j++) begin ev[k][j] = 1'b0; er[k][j] = 0; ei[k][j] = 0; end
      end
    end else begin
      for (int k = 0; k < 2; k++) begin
        logic [31:0] d;
        int p;
        real ang;
        longint c, s, xr, xi;
        d   = m_acc[k] + ({28'd0, m_lfsr[3:0]} << 16);
        p   = int'(d[31:20]);
        ang = 2.0 * 3.141592653589793 * p / 4096.0;
        c   = osc($cos(ang));
        s   = osc($sin(ang));
        xr  = longint'(in_re);
        xi  = longint'(in_im);
        for (int j = 3; j > 0; j--) begin
          ev[k][j] = ev[k][j-1]; er[k][j] = er[k][j-1]; ei[k][j] = ei[k][j-1];
        end
        ev[k][0] = in_valid;
        er[k][0] = rq(xr * c - xi * s);
        ei[k][0] = rq(xr * s + xi * c);
        if (in_valid) m_acc[k] = m_acc[k] + m_inc[k];
      end
      m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    end
  end

  task automatic chk(input string what, input int k, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s inst%0d %s actual=%0d expected=%0d", cur_req, k, what, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      for (int k = 0; k < 2; k++) begin
        chk("valid", k, int'(ov[k]), int'(ev[k][3]));
        if (ev[k][3]) begin
          chk("re", k, int'(ore[k]), er[k][3]);
          chk("im", k, int'(oim[k]), ei[k][3]);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=%0d expected<=20000", cyc);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic drive(input bit v, input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    in_valid = v; in_re = a; in_im = b;
  endtask

  int unsigned seed = 32'h1234_5678;

  initial begin
    m_inc[0] = 32'hC000_0000;
    m_inc[1] = 32'd0 - 32'd313532612;
    // R1: outputs quiet under reset, even with a valid input pending
    repeat (3) @(negedge clk);
    in_valid = 1'b1; in_re = 16'sd1000; in_im = 16'sd2000;
    repeat (3) @(negedge clk);
    for (int k = 0; k < 2; k++) chk("valid in reset", k, int'(ov[k]), 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cur_req = "R1/R3";
    drive(1'b1, 16'sd12000, -16'sd5000);
    cur_req = "R3/R4/R5/R6";
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      drive(1'b1, seed[31:16], seed[15:0]);
    end
    cur_req = "R2/R9";
    for (int i = 0; i < 300; i++) begin
      seed = seed * 32'd1664525 + 32'd1013904223;
      drive((i % 3) != 0 && seed[4], seed[31:16], seed[15:0]);
    end
    cur_req = "R8";
    for (int i = 0; i < 60; i++) begin
      case (i % 3)
        0:       drive(1'b1, 16'sh7FFF, 16'sh7FFF);
        1:       drive(1'b1, 16'sh8000, 16'sh8000);
        default: drive(1'b1, 16'sh7FFF, 16'sh8000);
      endcase
    end
    cur_req = "R7";
    for (int i = 0; i < 120; i++) begin
      if (i % 2 == 0) drive(1'b1, 16'sd8192, 16'sd8192);
      else            drive(1'b1, -16'sd8192, 16'sd8192);
    end
    cur_req = "R2/R9";
    for (int i = 0; i < 8; i++) drive(1'b0, 16'sh5555, 16'shAAAA);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule